// File: doc/BRIEF.md
# Compare, Branch and Trap Condition Unit

This unit evaluates every relational condition that a 32-bit RISC datapath needs, and it serves three kinds of operation from one shared condition core. A compare operation returns a full-width word that holds 1 when the chosen relation between the two operands is true and 0 when it is false. A branch operation tests a single register against zero and raises a taken flag. A trap operation raises a one-cycle trap request, one clock after the operation is presented.

The second operand is either a register value or a 16-bit immediate. The signedness flag chooses how the immediate is widened: it is sign-extended for signed forms and zero-extended for unsigned forms. The same flag also chooses between signed and unsigned ordering for the less-than and greater-than family of relations.

Decode logic drives the condition code, the signedness flag, the immediate-select flag and the operation class, together with a valid strobe. An unconditional branch comes from an eq branch on the zero register, which always reads as zero.

Top module: `cbt_cond_unit`

## Requirements
- R1: For a valid compare operation (class 0) with register operands and signed ordering, `cmp_result_o` is 1 when the relation holds and 0 otherwise. The condition codes are 0 eq, 1 ne, 2 lt, 3 le, 4 gt and 5 ge.
- R2: When `unsigned_i` is 1, codes 2 to 5 compare the operands as unsigned numbers. Codes 0 and 1 give the same result for either value of the flag.
- R3: When `use_imm_i` is 1 and `unsigned_i` is 0, the second comparand is `imm_i` sign-extended to 32 bits.
- R4: When `use_imm_i` is 1 and `unsigned_i` is 1, the second comparand is `imm_i` zero-extended to 32 bits, and the relation uses unsigned ordering.
- R5: For a valid branch operation (class 1), `branch_taken_o` is 1 exactly when the signed relation between `opa_i` and zero holds. `opb_i`, `imm_i`, `use_imm_i` and `unsigned_i` have no effect on a branch.
- R6: Code 6 (branch-true) behaves as ne and code 7 (branch-false) behaves as eq. Codes 8 to 15 never hold.
- R7: For a valid trap operation (class 2), `trap_o` is 1 for exactly one cycle, in the cycle after the clock edge that samples the operation, when the condition holds. It uses the same operand and ordering rules as a compare.
- R8: Each output responds only to its own class. `cmp_result_o` and `branch_taken_o` are 0, and no trap follows, when `valid_i` is 0, when the class is 3, or when the class belongs to another output.
- R9: While `rst_n` is low, and in the first cycle after reset is released, `trap_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| valid_i | input | 1 | Operation present this cycle |
| op_class_i | input | 2 | 0 compare, 1 branch, 2 trap, 3 none |
| cond_i | input | 4 | Condition code (see R1, R6) |
| unsigned_i | input | 1 | Unsigned ordering and zero extension of the immediate |
| use_imm_i | input | 1 | Second comparand taken from the immediate |
| opa_i | input | 32 | First operand; the tested register for branches |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| cmp_result_o | output | 32 | Compare result, 1 or 0 |
| branch_taken_o | output | 1 | Branch condition holds |
| trap_o | output | 1 | Registered one-cycle trap request |

## Verification
Directed patterns place the operands on the boundaries that separate the relations:
- equal values;
- neighbours that differ by one;
- the most negative and the most positive word;
- pairs whose sign bits differ, where signed and unsigned ordering disagree;
- immediates with bit 15 set, where sign and zero extension give different values.

Branch patterns set `opb_i` and the immediate to values that would change the result if they leaked into the test against zero. Random sweeps over all four classes and all sixteen codes are compared each cycle with a behavioural model in the bench. These sweeps confirm that each output fires only for its own class, and that a trap appears exactly one cycle after its operation.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned COND_W = 4;
  localparam int unsigned CLS_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_CMP    = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_TRAP   = 2'd2,
    CLS_NONE   = 2'd3
  } op_class_e;

  typedef enum logic [COND_W-1:0] {
    CC_EQ    = 4'd0,
    CC_NE    = 4'd1,
    CC_LT    = 4'd2,
    CC_LE    = 4'd3,
    CC_GT    = 4'd4,
    CC_GE    = 4'd5,
    CC_TRUE  = 4'd6,
    CC_FALSE = 4'd7
  } cond_e;

endpackage

// File: rtl/cbt_operand_sel.sv
module cbt_operand_sel
  import cbt_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic [CLS_W-1:0] op_class,
  input  logic             use_imm,
  input  logic             is_unsigned,
  input  logic [DW-1:0]    opb,
  input  logic [IW-1:0]    imm,
  output logic [DW-1:0]    rhs,
  output logic             rhs_unsigned
);

  localparam int unsigned PAD_W = DW - IW;

  logic [DW-1:0] imm_ext;

  always_comb begin
    if (is_unsigned) imm_ext = {{PAD_W{1'b0}}, imm};
    else             imm_ext = {{PAD_W{imm[IW-1]}}, imm};
  end

  always_comb begin
    if (op_class == CLS_BRANCH) begin
      rhs          = '0;
      rhs_unsigned = 1'b0;
    end else begin
      rhs          = use_imm ? imm_ext : opb;
      rhs_unsigned = is_unsigned;
    end
  end

endmodule

// File: rtl/cbt_relation.sv
module cbt_relation
  import cbt_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0]     lhs,
  input  logic [DW-1:0]     rhs,
  input  logic              is_unsigned,
  input  logic [COND_W-1:0] cond,
  output logic              holds
);

  logic [DW-1:0] bias;
  logic          is_eq;
  logic          is_lt;

  // Flipping the sign bit maps signed order onto unsigned order.
  always_comb begin
    bias  = is_unsigned ? '0 : {1'b1, {(DW-1){1'b0}}};
    is_eq = (lhs == rhs);
    is_lt = ((lhs ^ bias) < (rhs ^ bias));
  end

  always_comb begin
    unique case (cond)
      CC_EQ, CC_FALSE: holds = is_eq;
      CC_NE, CC_TRUE:  holds = !is_eq;
      CC_LT:           holds = is_lt;
      CC_LE:           holds = is_lt | is_eq;
      CC_GT:           holds = !(is_lt | is_eq);
      CC_GE:           holds = !is_lt;
      default:         holds = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbt_cond_unit.sv
module cbt_cond_unit
  import cbt_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [CLS_W-1:0]  op_class_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              unsigned_i,
  input  logic              use_imm_i,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  input  logic [IW-1:0]     imm_i,
  output logic [DW-1:0]     cmp_result_o,
  output logic              branch_taken_o,
  output logic              trap_o
);

  logic [DW-1:0] rhs;
  logic          rhs_unsigned;
  logic          holds;
  logic          trap_d;
  logic          trap_en;

  cbt_operand_sel #(.DW(DW), .IW(IW)) u_opsel (
    .op_class     (op_class_i),
    .use_imm      (use_imm_i),
    .is_unsigned  (unsigned_i),
    .opb          (opb_i),
    .imm          (imm_i),
    .rhs          (rhs),
    .rhs_unsigned (rhs_unsigned)
  );

  cbt_relation #(.DW(DW)) u_rel (
    .lhs         (opa_i),
    .rhs         (rhs),
    .is_unsigned (rhs_unsigned),
    .cond        (cond_i),
    .holds       (holds)
  );

  always_comb begin
    cmp_result_o   = '0;
    cmp_result_o[0] = valid_i && (op_class_i == CLS_CMP) && holds;
    branch_taken_o = valid_i && (op_class_i == CLS_BRANCH) && holds;
  end

  // Next state of the trap register; the enable lets a pending pulse clear.
  always_comb begin
    trap_d  = valid_i && (op_class_i == CLS_TRAP) && holds;
    trap_en = trap_d | trap_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trap_o <= 1'b0;
    else if (trap_en) trap_o <= trap_d;
  end

endmodule

// File: rtl/cbt_cond_unit_chk.sv
module cbt_cond_unit_chk
  import cbt_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [CLS_W-1:0]  op_class_i,
  input logic [COND_W-1:0] cond_i,
  input logic [DW-1:0]     opa_i,
  input logic [DW-1:0]     cmp_result_o,
  input logic              branch_taken_o,
  input logic              trap_o
);

  // R1: compare result is only ever 0 or 1
  a_r1_cmp_binary: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_result_o[DW-1:1] == '0);

  // R8: compare output only for a valid compare
  a_r8_cmp_own_class: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_result_o[0] |-> (valid_i && op_class_i == CLS_CMP));

  // R8: branch flag only for a valid branch
  a_r8_branch_own_class: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken_o |-> (valid_i && op_class_i == CLS_BRANCH));

  // R7: a trap follows a valid trap operation one cycle earlier
  a_r7_trap_follows_op: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(valid_i && op_class_i == CLS_TRAP));

  // R5: an eq branch is taken exactly when the tested register is zero
  a_r5_branch_eq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_class_i == CLS_BRANCH && cond_i == CC_EQ)
      |-> (branch_taken_o == (opa_i == '0)));

  // R6: codes 8..15 never hold
  a_r6_high_codes_false: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i >= 4'd8) |-> (!branch_taken_o && cmp_result_o == '0));

  // R6: codes 8..15 never raise a trap
  a_r6_high_codes_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_class_i == CLS_TRAP && cond_i >= 4'd8) |=> !trap_o);

endmodule

bind cbt_cond_unit cbt_cond_unit_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .valid_i        (valid_i),
  .op_class_i     (op_class_i),
  .cond_i         (cond_i),
  .opa_i          (opa_i),
  .cmp_result_o   (cmp_result_o),
  .branch_taken_o (branch_taken_o),
  .trap_o         (trap_o)
);

// File: tb/sim_cbt_cond_unit.sv
module sim_cbt_cond_unit;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  op_class_i;
  logic [3:0]  cond_i;
  logic        unsigned_i;
  logic        use_imm_i;
  logic [31:0] opa_i;
  logic [31:0] opb_i;
  logic [15:0] imm_i;
  logic [31:0] cmp_result_o;
  logic        branch_taken_o;
  logic        trap_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit pend_trap = 1'b0;
  string pend_tag = "R7";

  always #(CLK_PERIOD/2) clk = ~clk;

  cbt_cond_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_class_i(op_class_i),
    .cond_i(cond_i), .unsigned_i(unsigned_i), .use_imm_i(use_imm_i),
    .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .cmp_result_o(cmp_result_o), .branch_taken_o(branch_taken_o), .trap_o(trap_o)
  );

  // Behavioural reference: relation on 64-bit integers.
  function automatic bit model_rel(input logic [31:0] a, input logic [31:0] b,
                                   input bit uns, input logic [3:0] c);
    longint x;
    longint y;
    if (uns) begin
      x = longint'({32'd0, a});
      y = longint'({32'd0, b});
    end else begin
      x = longint'($signed(a));
      y = longint'($signed(b));
    end
    case (c)
      4'd0, 4'd7: return x == y;
      4'd1, 4'd6: return x != y;
      4'd2: return x <  y;
      4'd3: return x <= y;
      4'd4: return x >  y;
      4'd5: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One operation per cycle: inputs change at the falling edge; the trap of
  // the previous operation is checked just before they change.
  task automatic apply(input bit v, input logic [1:0] cls, input logic [3:0] c,
                       input bit uns, input bit ui, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im);
    logic [31:0] rhs;
    bit          r;
    bit          e_cmp;
    bit          e_br;
    string       tag;
    @(negedge clk);
    check(pend_tag, "trap", {31'd0, trap_o}, {31'd0, pend_trap});
    valid_i = v; op_class_i = cls; cond_i = c; unsigned_i = uns;
    use_imm_i = ui; opa_i = a; opb_i = b; imm_i = im;
    if (cls == 2'd1) r = model_rel(a, 32'd0, 1'b0, c);
    else begin
      rhs = ui ? (uns ? {16'd0, im} : {{16{im[15]}}, im}) : b;
      r   = model_rel(a, rhs, uns, c);
    end
    e_cmp = v && cls == 2'd0 && r;
    e_br  = v && cls == 2'd1 && r;
    if (!v || cls == 2'd3)  tag = "R8";
    else if (c >= 4'd6)     tag = "R6";
    else if (cls == 2'd1)   tag = "R5";
    else if (cls == 2'd2)   tag = "R7";
    else if (ui)            tag = uns ? "R4" : "R3";
    else                    tag = uns ? "R2" : "R1";
    #1;
    check(tag, "cmp_result", cmp_result_o, {31'd0, e_cmp});
    check(tag, "branch_taken", {31'd0, branch_taken_o}, {31'd0, e_br});
    pend_trap = v && cls == 2'd2 && r;
    pend_tag  = (tag == "R8") ? "R8" : "R7";
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_class_i = 2'd3; cond_i = 4'd0;
    unsigned_i = 1'b0; use_imm_i = 1'b0; opa_i = '0; opb_i = '0; imm_i = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "trap in reset", {31'd0, trap_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "trap after reset", {31'd0, trap_o}, 32'd0);

    // R1: signed register compares around equal and adjacent values
    for (int c = 0; c < 6; c++) begin
      apply(1, 2'd0, 4'(c), 0, 0, 32'd5, 32'd5, 16'd0);
      apply(1, 2'd0, 4'(c), 0, 0, 32'd4, 32'd5, 16'd0);
      apply(1, 2'd0, 4'(c), 0, 0, 32'h8000_0000, 32'h7fff_ffff, 16'd0);
    end
    // R2: differing sign bits split signed from unsigned ordering
    for (int c = 0; c < 6; c++) begin
      apply(1, 2'd0, 4'(c), 1, 0, 32'hffff_ffff, 32'd1, 16'd0);
      apply(1, 2'd0, 4'(c), 0, 0, 32'hffff_ffff, 32'd1, 16'd0);
      apply(1, 2'd0, 4'(c), 1, 0, 32'd7, 32'd7, 16'd0);
    end
    // R3 / R4: immediate with bit 15 set
    for (int c = 0; c < 6; c++) begin
      apply(1, 2'd0, 4'(c), 0, 1, 32'hffff_8000, 32'd0, 16'h8000);
      apply(1, 2'd0, 4'(c), 1, 1, 32'hffff_8000, 32'd0, 16'h8000);
      apply(1, 2'd0, 4'(c), 1, 1, 32'h0000_8000, 32'd0, 16'h8000);
      apply(1, 2'd0, 4'(c), 0, 1, 32'h0000_0000, 32'd0, 16'hffff);
    end
    // R5: branches ignore opb, imm and flags
    for (int c = 0; c < 8; c++) begin
      apply(1, 2'd1, 4'(c), 1, 1, 32'd0, 32'h1234, 16'hffff);
      apply(1, 2'd1, 4'(c), 1, 0, 32'hffff_fff0, 32'hffff_fff0, 16'd3);
      apply(1, 2'd1, 4'(c), 0, 1, 32'd9, 32'd100, 16'h8000);
    end
    // R6: high codes never hold
    for (int c = 8; c < 16; c++) begin
      apply(1, 2'd0, 4'(c), 0, 0, 32'd1, 32'd1, 16'd0);
      apply(1, 2'd1, 4'(c), 0, 0, 32'd0, 32'd0, 16'd0);
      apply(1, 2'd2, 4'(c), 0, 0, 32'd1, 32'd1, 16'd0);
    end
    // R7: back-to-back traps, then a false trap, then a gap
    apply(1, 2'd2, 4'd0, 0, 0, 32'd3, 32'd3, 16'd0);
    apply(1, 2'd2, 4'd2, 1, 1, 32'd3, 32'd0, 16'h8000);
    apply(1, 2'd2, 4'd4, 0, 1, 32'd3, 32'd0, 16'h8000);
    apply(1, 2'd2, 4'd0, 0, 0, 32'd3, 32'd4, 16'd0);
    apply(0, 2'd3, 4'd0, 0, 0, 32'd0, 32'd0, 16'd0);
    // R8: invalid or reserved class with conditions that would hold
    apply(0, 2'd2, 4'd0, 0, 0, 32'd1, 32'd1, 16'd0);
    apply(0, 2'd0, 4'd0, 0, 0, 32'd1, 32'd1, 16'd0);
    apply(1, 2'd3, 4'd0, 0, 0, 32'd1, 32'd1, 16'd0);
    apply(0, 2'd1, 4'd0, 0, 0, 32'd0, 32'd0, 16'd0);
    // Random sweep over all classes and codes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom;
      int          k  = $urandom_range(0, 3);
      if (k == 0) rb = ra;
      if (k == 1) rb = ra + 32'd1;
      apply(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
            4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), ra, rb, (k == 2) ? ra[15:0] : 16'($urandom));
    end
    apply(0, 2'd3, 4'd0, 0, 0, 32'd0, 32'd0, 16'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule